// File: doc/BRIEF.md
# Time Slot Interchanger

This block reorders the 8-bit samples of a framed time-division stream. Samples carry no address. Each one is known only by its slot position, which is counted from a frame-start marker. Every sample of a frame is stored in one of two memory banks, in the order it arrives. During the next frame that bank is read in the order set by a programmable permutation table. An output slot can therefore carry any input slot of the frame before it. The output frame has the same shape as the input frame and runs in lockstep with it, one clock behind.

The permutation table gives, for each output slot, the input slot whose sample it carries. Software fills a staging copy through a one-cycle write port. The copy is moved into the working table when a frame-start marker is accepted, so a frame never sees a partly changed mapping. The two sample banks trade roles at every accepted marker. One bank fills while the other is drained.

Top module: `slot_interchange`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_frame_start and out_sample are all zero.
- R2: out_valid stays low until the second accepted frame-start marker after reset. An accepted marker is one with in_valid high. The first valid output is the slot-0 output of the frame that marker opens.
- R3: After priming, out_valid in a cycle equals in_valid in the cycle before. out_frame_start equals (in_valid and in_frame_start) in the cycle before. out_sample changes only in cycles where out_valid is high.
- R4: The output for slot o of a frame carries the sample that arrived in slot map[o] of the previous frame. Here map[o] is the table entry at address o.
- R5: The slot index advances by one on each cycle with in_valid high. Cycles with in_valid low do not advance it. After slot SLOTS-1 it wraps to 0 without a marker, and a later sample then overwrites the earlier one in the same bank.
- R6: An accepted marker always makes its sample slot 0 and swaps the banks, even when it arrives before slot SLOTS-1.
- R7: A table write (map_wr_en with address o and data s) takes effect from the next accepted marker. A write made in the same cycle as a marker takes effect from the marker after that.
- R8: After reset the table holds the identity mapping (entry i = i).
- R9: in_frame_start has no effect in a cycle where in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input sample is present this cycle |
| in_frame_start | input | 1 | The present sample is slot 0 of a new frame |
| in_sample | input | 8 | Input sample |
| map_wr_en | input | 1 | Write one table entry |
| map_wr_addr | input | 5 | Output slot to program |
| map_wr_data | input | 5 | Input slot that the output slot will carry |
| out_valid | output | 1 | An output sample is present |
| out_frame_start | output | 1 | The output sample is slot 0 of a frame |
| out_sample | output | 8 | Output sample |

## Verification
The checker enforces on every cycle the one-cycle timing of out_valid and out_frame_start against the inputs, and that out_sample holds steady through idle cycles. It also checks that no output is valid before two markers have been accepted. Whether the right sample reaches each output slot can only be shown by the bench scenarios. These run a reference of the permutation against several mapping patterns, idle gaps, counter wrap, early markers and table writes timed around marker cycles.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/tsi_slot_counter.sv
module tsi_slot_counter
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_frame_start,
  output logic [IDX_W-1:0] slot_idx,
  output logic             boundary,
  output logic             live,
  output bank_e            wr_bank,
  output bank_e            rd_bank
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  bank_e            bank_q, bank_d;
  logic [1:0]       marks_q, marks_d;
  logic             cnt_en, bank_en, marks_en;

  // next-state
  always_comb begin
    boundary = in_valid & in_frame_start;
    slot_idx = boundary ? '0 : cnt_q;
    cnt_en   = in_valid;
    cnt_d    = (slot_idx == LAST) ? '0 : slot_idx + 1'b1;
    bank_en  = boundary;
    bank_d   = other_bank(bank_q);
    marks_en = boundary & (marks_q != 2'd2);
    marks_d  = marks_q + 2'd1;
    wr_bank  = boundary ? bank_d : bank_q;
    rd_bank  = other_bank(wr_bank);
    live     = boundary ? (marks_q != 2'd0) : (marks_q == 2'd2);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bank_q  <= BANK_A;
      marks_q <= 2'd0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (bank_en)  bank_q  <= bank_d;
      if (marks_en) marks_q <= marks_d;
    end
  end
endmodule

// File: rtl/tsi_map_table.sv
module tsi_map_table #(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [IDX_W-1:0] wr_data,
  input  logic             boundary,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [IDX_W-1:0] rd_src
);
  logic [IDX_W-1:0] shadow_q [SLOTS];
  logic [IDX_W-1:0] active_q [SLOTS];
  logic             wr_ok;

  always_comb begin
    wr_ok  = wr_en & (int'(wr_addr) < SLOTS);
    // on a boundary cycle the staged table already governs slot 0
    rd_src = boundary ? shadow_q[rd_slot] : active_q[rd_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        shadow_q[i] <= IDX_W'(i);
        active_q[i] <= IDX_W'(i);
      end
    end else begin
      if (wr_ok) shadow_q[wr_addr] <= wr_data;
      if (boundary) begin
        for (int i = 0; i < SLOTS; i++) active_q[i] <= shadow_q[i];
      end
    end
  end
endmodule

// File: rtl/tsi_sample_store.sv
module tsi_sample_store
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  bank_e            wr_bank,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [W-1:0]     wr_data,
  input  bank_e            rd_bank,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [W-1:0] mem [SLOTS];
    logic         we;

    always_comb we = wr_en & (wr_bank == bank_e'(b));

    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= wr_data;
    end

    always_comb bank_rd[b] = mem[rd_addr];
  end

  always_comb rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/slot_interchange.sv
module slot_interchange
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_frame_start,
  input  logic [W-1:0]     in_sample,
  input  logic             map_wr_en,
  input  logic [IDX_W-1:0] map_wr_addr,
  input  logic [IDX_W-1:0] map_wr_data,
  output logic             out_valid,
  output logic             out_frame_start,
  output logic [W-1:0]     out_sample
);
  logic [IDX_W-1:0] slot_idx, src_idx;
  logic             boundary, live;
  bank_e            wr_bank, rd_bank;
  logic [W-1:0]     rd_data;

  logic             ov_d, ofs_d, os_en;
  logic             ov_q, ofs_q;
  logic [W-1:0]     os_q;

  tsi_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame_start(in_frame_start),
    .slot_idx(slot_idx), .boundary(boundary), .live(live),
    .wr_bank(wr_bank), .rd_bank(rd_bank)
  );

  tsi_map_table #(.SLOTS(SLOTS)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(map_wr_en), .wr_addr(map_wr_addr),
    .wr_data(map_wr_data), .boundary(boundary), .rd_slot(slot_idx), .rd_src(src_idx)
  );

  tsi_sample_store #(.SLOTS(SLOTS), .W(W)) u_store (
    .clk(clk), .wr_en(in_valid), .wr_bank(wr_bank), .wr_addr(slot_idx),
    .wr_data(in_sample), .rd_bank(rd_bank), .rd_addr(src_idx), .rd_data(rd_data)
  );

  // next-state
  always_comb begin
    ov_d  = in_valid & live;
    ofs_d = boundary & live;
    os_en = ov_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      ofs_q <= 1'b0;
      os_q  <= '0;
    end else begin
      ov_q  <= ov_d;
      ofs_q <= ofs_d;
      if (os_en) os_q <= rd_data;
    end
  end

  assign out_valid       = ov_q;
  assign out_frame_start = ofs_q;
  assign out_sample      = os_q;
endmodule

// File: rtl/tsi_chk.sv
module tsi_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_frame_start,
  input logic         out_valid,
  input logic         out_frame_start,
  input logic [W-1:0] out_sample
);
  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 2'd0;
    else if (in_valid && in_frame_start && seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  // R2
  primed_before_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen_q == 2'd2));

  // R3
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3
  marker_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_start |-> ($past(in_valid && in_frame_start) && out_valid));

  // R3
  sample_held_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));

  // R9
  idle_marker_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_frame_start) |=> (!out_valid && !out_frame_start));
endmodule

bind slot_interchange tsi_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame_start(in_frame_start),
  .out_valid(out_valid), .out_frame_start(out_frame_start), .out_sample(out_sample)
);

// File: tb/slot_interchange_tb.sv
module slot_interchange_tb;
  localparam int N = 32;
  localparam int IW = $clog2(N);
  // vectors: {stride (odd), offset, idle gap every k slots (0 = none)}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{1, 0, 0}, '{1, 7, 0}, '{3, 5, 4}, '{31, 0, 0}, '{5, 11, 3}, '{7, 2, 1}};

  logic clk, rst_n;
  logic in_valid, in_frame_start;
  logic [7:0] in_sample;
  logic map_wr_en;
  logic [IW-1:0] map_wr_addr, map_wr_data;
  logic out_valid, out_frame_start;
  logic [7:0] out_sample;

  slot_interchange #(.SLOTS(N), .W(8)) u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests, fails, seq;
  bit done;
  string tag;

  // reference state
  int   m_act [N], m_pend [N];
  logic [7:0] m_prev [N], m_cur [N];
  bit   m_prevk [N], m_curk [N];
  int   m_cnt, m_marks;
  bit   e_v, e_fs, e_k;
  logic [7:0] e_d;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_v, "out_valid", int'(out_valid), int'(e_v));
    chk(out_frame_start == e_fs, "out_frame_start", int'(out_frame_start), int'(e_fs));
    if (e_k) chk(out_sample == e_d, "out_sample", int'(out_sample), int'(e_d));
  endtask

  task automatic step(input bit v, input bit fs, input bit we, input int wa, input int wd);
    int slot;
    logic [7:0] d;
    @(negedge clk);
    compare();
    d = 8'((seq * 29 + 7) & 255);
    in_valid = v; in_frame_start = fs; in_sample = d;
    map_wr_en = we; map_wr_addr = IW'(wa); map_wr_data = IW'(wd);
    if (v) begin
      seq++;
      if (fs) begin
        m_prev = m_cur; m_prevk = m_curk;
        for (int i = 0; i < N; i++) m_curk[i] = 1'b0;
        m_act = m_pend;
        if (m_marks < 2) m_marks++;
        slot = 0;
      end else slot = m_cnt;
      e_v = (m_marks >= 2);
      e_fs = fs && e_v;
      if (e_v) begin
        e_k = m_prevk[m_act[slot]];
        e_d = m_prev[m_act[slot]];
      end
      m_cur[slot] = d; m_curk[slot] = 1'b1;
      m_cnt = (slot == N - 1) ? 0 : slot + 1;
    end else begin
      e_v = 1'b0; e_fs = 1'b0;
    end
    if (we) m_pend[wa] = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic frame(input int nslots, input int gap);
    for (int i = 0; i < nslots; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) step(1'b0, 1'b0, 1'b0, 0, 0);
      step(1'b1, i == 0, 1'b0, 0, 0);
    end
  endtask

  task automatic program_map(input int stride, input int off);
    for (int o = 0; o < N; o++) step(1'b0, 1'b0, 1'b1, o, (stride * o + off) % N);
  endtask

  initial begin
    tests = 0; fails = 0; seq = 1; done = 0; tag = "R1";
    for (int i = 0; i < N; i++) begin
      m_act[i] = i; m_pend[i] = i; m_prevk[i] = 0; m_curk[i] = 0;
      m_prev[i] = '0; m_cur[i] = '0;
    end
    m_cnt = 0; m_marks = 0;
    e_v = 0; e_fs = 0; e_k = 1; e_d = '0;
    in_valid = 0; in_frame_start = 0; in_sample = '0;
    map_wr_en = 0; map_wr_addr = '0; map_wr_data = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                       // R1 during reset
    rst_n = 1;
    idle(2);                         // R1 after release

    // R9: markers with in_valid low are ignored, before and inside a frame
    tag = "R9";
    step(1'b0, 1'b1, 1'b0, 0, 0);
    frame(N / 2, 0);
    step(1'b0, 1'b1, 1'b0, 0, 0);
    for (int i = 0; i < N / 2; i++) step(1'b1, 1'b0, 1'b0, 0, 0);
    // R2: still invalid through the first marked frame, live from the second
    tag = "R2";
    frame(N, 0);
    tag = "R8";                      // identity after reset
    frame(N, 0);
    frame(N, 2);

    // vector table walk: R4 with R5 idle gaps
    for (int v = 0; v < NV; v++) begin
      tag = "R4";
      program_map(VEC[v][0], VEC[v][1]);
      frame(N, VEC[v][2]);
      frame(N, VEC[v][2]);
    end

    // R7: write mid-frame, old map used until next marker
    tag = "R7";
    program_map(1, 0);
    frame(N, 0);
    step(1'b1, 1'b1, 1'b0, 0, 0);
    for (int i = 1; i < N; i++) step(1'b1, 1'b0, 1'b1, i, (i + 9) % N);
    frame(N, 0);
    frame(N, 0);
    // R7: write in the same cycle as a marker
    program_map(1, 0);
    frame(N, 0);
    step(1'b1, 1'b1, 1'b1, 0, 13);
    for (int i = 1; i < N; i++) step(1'b1, 1'b0, 1'b0, 0, 0);
    frame(N, 0);
    frame(N, 0);

    // R5: counter wraps without a marker
    tag = "R5";
    program_map(3, 1);
    frame(N + 5, 0);
    frame(N, 0);
    frame(N, 0);

    // R6: early markers restart at slot 0
    tag = "R6";
    frame(9, 0);
    frame(N, 0);
    frame(5, 0);
    frame(N, 1);
    idle(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule